// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the command register of a per-CPU local interrupt controller. Software uses it to send an inter-processor interrupt, including a non-maskable one, to another CPU chosen by its ID. It has a 32-bit register port for reads and writes. It also has a read-only register that reports this CPU's own ID, and an outgoing message port. Each message carries a destination ID, a delivery mode, a vector and a level bit, and is passed on with a valid/ready handshake.

The command is split across two words. Software first writes the high word, which holds the destination ID. It then writes the low word, which holds the mode, the level and the vector. Only the write to the low word launches a message. The message is captured when the low word is written, so later writes to the high word do not change a message that is still waiting.

While a message is waiting, the low word reports a pending flag. A second write to the low word is held off by the register port's ready signal until the fabric accepts the waiting message. Reserved bits ignore writes and always read as zero. Receiving the interrupt at the destination CPU and the interconnect fabric are outside this block.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset the outgoing message valid is 0, and the low and high command words both read 0.
- R2: A read at offset 0x020 returns the CPU's own ID (the `self_id` input) in bits 31:24 and zero in all other bits. Writes to 0x020 have no effect.
- R3: The high command word is at offset 0x310. Bits 31:24 hold the destination ID and read back what was last written. Bits 23:0 always read 0. A write to the high word alone never raises the message valid.
- R4: The low command word is at offset 0x300. An accepted write to it raises `ipi_valid` on the next cycle. The message then carries:
  - the destination taken from high-word bits 31:24 as they were at the time of the write;
  - the mode taken from written bits 10:8;
  - the level taken from written bit 14.
- R5: Delivery mode value 3'b100 means a non-maskable interrupt, and its message carries vector 0. Every other mode value carries written bits 7:0 as the vector. Writing 0x4400 therefore sends an asserted non-maskable interrupt.
- R6: In the low word, bits 7:0, 11:8, 14, 15 and 19:18 read back what was last written. Reserved bits 13, 17:16 and 31:20 always read 0, whatever is written to them.
- R7: Low-word bit 12 is a read-only pending flag. It reads 1 from the cycle after a triggering write up to and including the cycle in which `ipi_valid && ipi_ready` is seen. Writes to bit 12 do not set it.
- R8: While `ipi_valid` is high and `ipi_ready` is low, `ipi_valid` stays high and the destination, mode, vector and level stay unchanged.
- R9: While a message is pending, a write to the low word sees `req_ready` low and is neither stored nor sent. Writes to other offsets and all reads see `req_ready` high.
- R10: Reads at any other offset return 0, and writes to them change no register and send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | 8 | This CPU's ID, reported by the ID register |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset of the register |
| req_wdata | input | 32 | Write data, always a full 32-bit word |
| req_ready | output | 1 | Access accepted this cycle |
| rdata | output | 32 | Read data for `req_addr`, valid in the same cycle |
| ipi_valid | output | 1 | Outgoing message valid |
| ipi_ready | input | 1 | Fabric accepts the message |
| ipi_dest | output | 8 | Destination CPU ID |
| ipi_mode | output | 3 | Delivery mode (3'b100 = non-maskable) |
| ipi_vector | output | 8 | Interrupt vector (0 for non-maskable) |
| ipi_level | output | 1 | Level/assert bit |

## Verification
A wrong pending flag in this block shows up in three ways:
- a missing or repeated `ipi_valid`;
- a `req_ready` drop on a low-word write when no message is pending, or a missing drop when one is;
- a wrong bit 12 on the next low-word read.

A wrong message snapshot shows up as a destination, mode or vector on the message port that differs from what was written. Because the message port is registered one stage after the triggering write, every such fault is visible at the ports within one cycle of the write or of the handshake.

The reference model runs in lockstep and compares every cycle. Reserved-bit masking and address decoding show up on the very next read of the affected word.

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        self_id,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic [31:0]       rdata,
  output logic              ipi_valid,
  input  logic              ipi_ready,
  output logic [7:0]        ipi_dest,
  output logic [2:0]        ipi_mode,
  output logic [7:0]        ipi_vector,
  output logic              ipi_level
);

  localparam logic [ADDR_W-1:0] OFS_ID   = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] OFS_LOW  = ADDR_W'(12'h300);
  localparam logic [ADDR_W-1:0] OFS_HIGH = ADDR_W'(12'h310);
  localparam logic [31:0]       LOW_RW   = 32'h000C_CFFF;
  localparam logic [2:0]        MODE_NMI = 3'b100;
  localparam int                PEND_BIT = 12;

  logic [31:0] low_q;
  logic [7:0]  dest_q;
  logic        pend_q;

  wire hit_low  = (req_addr == OFS_LOW);
  wire hit_high = (req_addr == OFS_HIGH);
  wire hit_id   = (req_addr == OFS_ID);
  wire wr_low   = req_valid && req_write && hit_low && !pend_q;
  wire wr_high  = req_valid && req_write && hit_high;
  wire taken    = pend_q && ipi_ready;

  assign req_ready = !(req_write && hit_low && pend_q);
  assign ipi_valid = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q      <= '0;
      dest_q     <= '0;
      pend_q     <= 1'b0;
      ipi_dest   <= '0;
      ipi_mode   <= '0;
      ipi_vector <= '0;
      ipi_level  <= 1'b0;
    end else begin
      if (taken) pend_q <= 1'b0;
      if (wr_low) begin
        low_q      <= req_wdata & LOW_RW;
        pend_q     <= 1'b1;
        ipi_dest   <= dest_q;
        ipi_mode   <= req_wdata[10:8];
        ipi_level  <= req_wdata[14];
        ipi_vector <= (req_wdata[10:8] == MODE_NMI) ? 8'h00 : req_wdata[7:0];
      end
      if (wr_high) dest_q <= req_wdata[31:24];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_id) begin
      rdata[31:24] = self_id;
    end else if (hit_low) begin
      rdata           = low_q;
      rdata[PEND_BIT] = pend_q;
    end else if (hit_high) begin
      rdata[31:24] = dest_q;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid && !ipi_ready |=> ipi_valid && $stable(ipi_dest) && $stable(ipi_mode)
                               && $stable(ipi_vector) && $stable(ipi_level));

  assert_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && hit_low |=> ipi_valid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ipi_valid && !(req_valid && req_write && hit_low) |=> !ipi_valid);

  assert_low_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid && !ipi_ready |=> $stable(low_q));

  assert_nmi_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_valid && ipi_mode == MODE_NMI |-> ipi_vector == 8'h00);

  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_low |-> rdata[13] == 1'b0 && rdata[17:16] == 2'b00 && rdata[31:20] == 12'h000);

endmodule

// File: tb/ipi_cmd_reg_tb.sv
module ipi_cmd_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  self_id = 8'h5C;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rdata;
  logic        ipi_valid, ipi_ready = 1'b0, ipi_level;
  logic [7:0]  ipi_dest, ipi_vector;
  logic [2:0]  ipi_mode;

  ipi_cmd_reg u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // reference model state
  logic [31:0] m_low;
  logic [7:0]  m_dhigh, m_dest, m_vec;
  logic [2:0]  m_mode;
  logic        m_pend, m_lvl;

  function automatic logic [31:0] exp_rdata(input logic [11:0] a);
    if (a == 12'h020) return {self_id, 24'h0};
    if (a == 12'h300) return (m_low & 32'h000C_CFFF) | (32'(m_pend) << 12);
    if (a == 12'h310) return {m_dhigh, 24'h0};
    return 32'h0;
  endfunction

  task automatic step(input logic v, input logic w, input logic [11:0] a,
                      input logic [31:0] d, input logic rdy, input string tag);
    logic e_ready;
    logic [31:0] e_rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; ipi_ready = rdy;
    #1;
    e_ready = !(w && a == 12'h300 && m_pend);
    e_rd = exp_rdata(a);
    checks++;
    if (req_ready !== e_ready || rdata !== e_rd || ipi_valid !== m_pend ||
        (m_pend && (ipi_dest !== m_dest || ipi_mode !== m_mode ||
                    ipi_vector !== m_vec || ipi_level !== m_lvl))) begin
      fails++;
      $display("FAIL %s: actual rdy=%b rd=%h v=%b d=%h m=%0d vec=%h l=%b expected rdy=%b rd=%h v=%b d=%h m=%0d vec=%h l=%b",
               tag, req_ready, rdata, ipi_valid, ipi_dest, ipi_mode, ipi_vector, ipi_level,
               e_ready, e_rd, m_pend, m_dest, m_mode, m_vec, m_lvl);
    end
    if (m_pend && rdy) m_pend = 1'b0;
    else if (v && w && e_ready && a == 12'h300) begin
      m_low  = d & 32'h000C_CFFF;
      m_pend = 1'b1;
      m_dest = m_dhigh;
      m_mode = d[10:8];
      m_lvl  = d[14];
      m_vec  = (d[10:8] == 3'b100) ? 8'h00 : d[7:0];
    end
    if (v && w && a == 12'h310) m_dhigh = d[31:24];
  endtask

  logic [31:0] lfsr = 32'hACE1_1234;

  initial begin
    m_low = '0; m_dhigh = '0; m_dest = '0; m_vec = '0; m_mode = '0; m_pend = 0; m_lvl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    step(1, 0, 12'h300, 0, 0, "R1 low after reset");
    step(1, 0, 12'h310, 0, 0, "R1 high after reset");
    // R2 ID register
    step(1, 0, 12'h020, 0, 0, "R2 id read");
    step(1, 1, 12'h020, 32'hFFFF_FFFF, 0, "R2 id write ignored");
    step(1, 0, 12'h020, 0, 0, "R2 id read after write");
    // R3 high word
    step(1, 1, 12'h310, 32'hA5FF_FFFF, 0, "R3 high write");
    step(1, 0, 12'h310, 0, 0, "R3 high readback");
    step(0, 0, 12'h000, 0, 0, "R3 no send from high");
    // R4 R5 R6 fixed mode trigger, ready held low
    step(1, 1, 12'h300, 32'hFFFF_F031, 0, "R4 R6 low trigger mode 0");
    step(1, 0, 12'h300, 0, 0, "R7 pending read");
    step(1, 1, 12'h310, 32'h3300_0000, 0, "R8 high write while pending");
    step(1, 1, 12'h300, 32'h0000_4400, 0, "R9 low write blocked");
    step(1, 0, 12'h300, 0, 0, "R9 low unchanged");
    step(0, 0, 12'h000, 0, 0, "R8 hold");
    step(0, 0, 12'h000, 0, 1, "R7 handshake");
    step(1, 0, 12'h300, 0, 0, "R7 pending cleared");
    // R5 NMI
    step(1, 1, 12'h300, 32'h0000_44AB, 1, "R5 nmi trigger");
    step(0, 0, 12'h000, 0, 1, "R5 nmi message");
    step(1, 1, 12'h300, 32'h0000_1000, 0, "R7 write bit12 only");
    step(1, 0, 12'h300, 0, 1, "R7 readback");
    step(1, 0, 12'h300, 0, 0, "R7 cleared");
    // R10 unmapped
    step(1, 1, 12'h304, 32'hFFFF_FFFF, 0, "R10 unmapped write");
    step(1, 0, 12'h304, 0, 0, "R10 unmapped read");
    step(1, 0, 12'h310, 0, 0, "R10 high unchanged");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:2])
        2'd0: a = 12'h300; 2'd1: a = 12'h310; 2'd2: a = 12'h020; default: a = 12'h100;
      endcase
      step(lfsr[4], lfsr[5], a, {lfsr[15:0], lfsr[31:16]}, lfsr[7] & lfsr[6], "R4 R9 mixed");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule